// File: doc/BRIEF.md
# Multi-Mode Host Bus Slave Front End

This block lets one peripheral sit on any of four host processor buses: an ISA-style bus, an 80186-style bus, a 68000-style bus and an 8051-style bus. A two-bit strap captured during reset picks the bus style. Four more strap bits capture the polarity that four extra address-select inputs must show. The block turns the chosen bus's chip select, address, byte strobes and read/write lines into one neutral access. That access has an even byte, an odd byte and a word index, and it goes either to a byte-enabled register window or to a 16-bit data port.

On the host side the block puts the even and odd bytes on the lanes each bus expects. It drives read data only on the lanes being read, and it produces the handshake the bus needs. For most styles that handshake is a wait request while the data port is not ready. For the 68000 style it is a data acknowledge. The block also gives a 16-bit-port indication and an interrupt output whose polarity follows the mode. Tri-state lanes are modelled as data plus per-lane output enables. The open-drain pins are modelled as "pull low" enables.

Top module: `hbus_slave`

## Requirements
- R1: While `rst` is high, `strap_mode` and `strap_pol` are captured each cycle. After `rst` falls the captured values hold, and later changes on the strap inputs have no effect. Mode codes: 00 ISA, 01 80186, 10 68000, 11 8051.
- R2: While `cs_n` is high, both lane enables are low, no register or port strobe is issued, and `rdy_pull` and `io16_pull` are low.
- R3: In ISA and 80186 modes, `addr[0]` low enables the even byte and `bhe_n` low enables the odd byte. The even byte uses lane [7:0] and the odd byte uses lane [15:8]. `rd_n` and `wr_n` are the strobes, and when both are low the access is a read.
- R4: In 68000 mode, `addr[0]` is the upper data strobe (even byte, lane [15:8]) and `bhe_n` is the lower data strobe (odd byte, lane [7:0]), both active low. `wr_n` acts as read/write: high means read and low means write. `rd_n` is ignored.
- R5: In 8051 mode only lane [7:0] is used. `addr[0]` low selects the even byte and high selects the odd byte. An access is accepted only while `psen` is high.
- R6: The chip is selected only when `cs_n` is low, `addr[9:5]` equals the base tag (default 0x18), and `sel_x` equals the captured `strap_pol`.
- R7: `io16_pull` is high whenever the chip is selected at data-port word 8 (`addr[4:1]`==8), whatever the strobes, in every mode except 8051.
- R8: `irq_pin` equals `irq_req` in ISA and 80186 modes and is its inverse in 68000 and 8051 modes.
- R9: Outside 68000 mode, `rdy_pull` is high during a selected data-port access while `dp_ready` is low. In 68000 mode, `rdy_pull` is high during a selected access to a register, or to the port once `dp_ready` is high.
- R10: A register write issues exactly one `rf_wr` pulse, in the first cycle the selected write strobe is seen. The pulse carries `rf_idx`=`addr[4:1]`, `rf_be`={odd, even} and `rf_wdata`={odd byte, even byte} taken from the lanes of R3 to R5.
- R11: Read data appears only while a selected read strobe is active, and only on the lanes of the enabled bytes. Data is `rf_rdata`, or `dp_rdata` at word 8, with the odd byte in [15:8], placed on the lanes of R3 to R5.
- R12: A data-port write or read issues exactly one `dp_wr` or `dp_rd` pulse, in the first cycle the strobe is seen. A port write carries `dp_wdata`={odd, even}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| strap_mode | input | 2 | Bus style strap |
| strap_pol | input | 4 | Required levels for `sel_x` |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 10 | Host address; bit 0 is also the upper data strobe in 68000 mode |
| sel_x | input | 4 | Extra address-select inputs |
| bhe_n | input | 1 | High byte enable, or lower data strobe in 68000 mode |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, or read/write line in 68000 mode |
| psen | input | 1 | Program-store enable; must be high for 8051 accesses |
| din | input | 16 | Host write data lanes |
| dout | output | 16 | Host read data lanes |
| dout_oe | output | 2 | Lane drive enables: bit 0 for [7:0], bit 1 for [15:8] |
| rdy_pull | output | 1 | Pull the ready/acknowledge pin low |
| io16_pull | output | 1 | Pull the 16-bit-port indication low |
| irq_req | input | 1 | Internal interrupt request |
| irq_pin | output | 1 | Interrupt pin level |
| rf_idx | output | 4 | Register word index |
| rf_be | output | 2 | Register byte enables {odd, even} |
| rf_wr | output | 1 | Register write pulse |
| rf_wdata | output | 16 | Register write data {odd, even} |
| rf_rdata | input | 16 | Register read data {odd, even} |
| dp_rd | output | 1 | Data-port read pulse |
| dp_wr | output | 1 | Data-port write pulse |
| dp_wdata | output | 16 | Data-port write data {odd, even} |
| dp_rdata | input | 16 | Data-port read data {odd, even} |
| dp_ready | input | 1 | Data port can complete the access |

## Verification
The bench goes after the lane order in each mode. A design that swapped lanes in 68000 mode would write the bytes of a word backwards and return them backwards on reads. Odd-byte accesses in 8051 mode check that the odd byte comes back on the low lane; a design that got this wrong would drive the upper lane or return the even byte. Strap changes after reset, a wrong `sel_x` level, a wrong tag and `psen` held low check that a later strap value is not picked up and that an access is not accepted without a full match. Port accesses with `dp_ready` held low and then raised separate the wait polarity from the acknowledge polarity, and held strobes catch a write that repeats every cycle instead of pulsing once.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    typedef enum logic [1:0] {
        BUS_ISA = 2'b00,
        BUS_X86 = 2'b01,
        BUS_M68 = 2'b10,
        BUS_MCS = 2'b11
    } bus_mode_e;

    // Neutral access decoded from whichever host bus is active
    typedef struct packed {
        logic chip;     // selected (address, extension selects, psen)
        logic hit;      // selected with an active strobe and a byte enabled
        logic rd;
        logic wr;
        logic be_odd;
        logic be_even;
        logic port;     // word index addresses the 16-bit data port
    } acc_s;

    typedef struct packed {
        logic [7:0] odd;
        logic [7:0] even;
    } pair_s;

    function automatic logic irq_active_high(bus_mode_e m);
        return (m == BUS_ISA) || (m == BUS_X86);
    endfunction

    function automatic logic has_wide_port(bus_mode_e m);
        return m != BUS_MCS;
    endfunction

endpackage

// File: rtl/hbus_straps.sv
module hbus_straps
    import hbus_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode_in,
    input  logic [SEL_W-1:0] pol_in,
    output bus_mode_e        mode_o,
    output logic [SEL_W-1:0] pol_o
);
    bus_mode_e        mode_q;
    logic [SEL_W-1:0] pol_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= bus_mode_e'(mode_in);
            pol_q  <= pol_in;
        end
    end

    assign mode_o = mode_q;
    assign pol_o  = pol_q;

    // R1: captured straps never move once reset is gone
    a_r1_straps_held: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ($stable(mode_q) && $stable(pol_q)));

endmodule

// File: rtl/hbus_decode.sv
module hbus_decode
    import hbus_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int OFS_W     = 5,
    parameter int SEL_W     = 4,
    parameter int BASE_TAG  = 'h18,
    parameter int PORT_WORD = 8
) (
    input  bus_mode_e          mode,
    input  logic [SEL_W-1:0]   pol,
    input  logic               cs_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SEL_W-1:0]   sel_x,
    input  logic               bhe_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               psen,
    output acc_s               acc,
    output logic [OFS_W-2:0]   widx
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam int IDX_W = OFS_W - 1;

    logic tag_ok, sel_ok, psen_ok, strobe;

    assign widx = addr[OFS_W-1:1];

    always_comb begin
        tag_ok  = addr[ADDR_W-1:OFS_W] == TAG_W'(BASE_TAG);
        sel_ok  = sel_x == pol;
        psen_ok = (mode != BUS_MCS) || psen;

        acc         = '0;
        acc.chip    = !cs_n && tag_ok && sel_ok && psen_ok;
        acc.be_even = !addr[0];
        strobe      = 1'b0;

        unique case (mode)
            BUS_M68: begin
                // address bit 0 is the upper strobe, bhe_n the lower strobe
                acc.be_odd = !bhe_n;
                strobe     = !addr[0] || !bhe_n;
                acc.rd     = strobe && wr_n;
                acc.wr     = strobe && !wr_n;
            end
            BUS_MCS: begin
                acc.be_odd  = addr[0];
                acc.rd      = !rd_n;
                acc.wr      = !wr_n && rd_n;
            end
            default: begin
                acc.be_odd = !bhe_n;
                acc.rd     = !rd_n;
                acc.wr     = !wr_n && rd_n;
            end
        endcase

        acc.hit  = acc.chip && (acc.rd || acc.wr) && (acc.be_even || acc.be_odd);
        acc.port = widx == IDX_W'(PORT_WORD);
    end

endmodule

// File: rtl/hbus_lanes.sv
module hbus_lanes
    import hbus_pkg::*;
(
    input  bus_mode_e   mode,
    input  logic        be_odd,
    input  logic        be_even,
    input  logic        drive,
    input  logic [15:0] din,
    input  pair_s       rword,
    output pair_s       wpair,
    output logic [15:0] dout,
    output logic [1:0]  oe
);
    logic [1:0] lane_use;

    always_comb begin
        wpair    = '0;
        dout     = '0;
        lane_use = '0;
        unique case (mode)
            BUS_M68: begin
                // big-endian lane order: even byte high
                wpair.even = din[15:8];
                wpair.odd  = din[7:0];
                dout       = {rword.even, rword.odd};
                lane_use   = {be_even, be_odd};
            end
            BUS_MCS: begin
                wpair.even = din[7:0];
                wpair.odd  = din[7:0];
                dout       = {8'h00, be_odd ? rword.odd : rword.even};
                lane_use   = 2'b01;
            end
            default: begin
                wpair.even = din[7:0];
                wpair.odd  = din[15:8];
                dout       = {rword.odd, rword.even};
                lane_use   = {be_odd, be_even};
            end
        endcase
        oe = drive ? lane_use : 2'b00;
    end

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int OFS_W     = 5,
    parameter int SEL_W     = 4,
    parameter int BASE_TAG  = 'h18,
    parameter int PORT_WORD = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [1:0]         strap_mode,
    input  logic [SEL_W-1:0]   strap_pol,
    input  logic               cs_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [SEL_W-1:0]   sel_x,
    input  logic               bhe_n,
    input  logic               rd_n,
    input  logic               wr_n,
    input  logic               psen,
    input  logic [15:0]        din,
    output logic [15:0]        dout,
    output logic [1:0]         dout_oe,
    output logic               rdy_pull,
    output logic               io16_pull,
    input  logic               irq_req,
    output logic               irq_pin,
    output logic [OFS_W-2:0]   rf_idx,
    output logic [1:0]         rf_be,
    output logic               rf_wr,
    output logic [15:0]        rf_wdata,
    input  logic [15:0]        rf_rdata,
    output logic               dp_rd,
    output logic               dp_wr,
    output logic [15:0]        dp_wdata,
    input  logic [15:0]        dp_rdata,
    input  logic               dp_ready
);
    bus_mode_e        mode;
    logic [SEL_W-1:0] pol;
    acc_s             acc;
    pair_s            wpair, rword;
    logic             act_q, start, ack_ok;

    hbus_straps #(.SEL_W(SEL_W)) u_straps (
        .clk(clk), .rst(rst), .mode_in(strap_mode), .pol_in(strap_pol),
        .mode_o(mode), .pol_o(pol)
    );

    hbus_decode #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .SEL_W(SEL_W),
        .BASE_TAG(BASE_TAG), .PORT_WORD(PORT_WORD)
    ) u_dec (
        .mode(mode), .pol(pol), .cs_n(cs_n), .addr(addr), .sel_x(sel_x),
        .bhe_n(bhe_n), .rd_n(rd_n), .wr_n(wr_n), .psen(psen),
        .acc(acc), .widx(rf_idx)
    );

    assign rword = acc.port ? pair_s'(dp_rdata) : pair_s'(rf_rdata);

    hbus_lanes u_lanes (
        .mode(mode), .be_odd(acc.be_odd), .be_even(acc.be_even),
        .drive(acc.hit && acc.rd), .din(din), .rword(rword),
        .wpair(wpair), .dout(dout), .oe(dout_oe)
    );

    // strobe edge: one internal pulse per host access
    always_ff @(posedge clk) begin
        if (rst) act_q <= 1'b0;
        else     act_q <= acc.hit;
    end

    assign start    = acc.hit && !act_q;
    assign rf_wr    = start && acc.wr && !acc.port;
    assign dp_wr    = start && acc.wr && acc.port;
    assign dp_rd    = start && acc.rd && acc.port;
    assign rf_be    = {acc.be_odd, acc.be_even};
    assign rf_wdata = wpair;
    assign dp_wdata = wpair;

    assign ack_ok    = !acc.port || dp_ready;
    assign rdy_pull  = acc.hit && ((mode == BUS_M68) ? ack_ok : !ack_ok);
    assign io16_pull = acc.chip && acc.port && has_wide_port(mode);
    assign irq_pin   = irq_active_high(mode) ? irq_req : !irq_req;

    // R2: deselected bus is quiet
    a_r2_standby_quiet: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> (dout_oe == 2'b00 && !rf_wr && !dp_wr && !dp_rd && !rdy_pull && !io16_pull));

    // R5: byte-wide host never sees the upper lane driven
    a_r5_upper_lane_idle: assert property (@(posedge clk) disable iff (rst)
        (mode == BUS_MCS) |-> !dout_oe[1]);

    // R7: no 16-bit indication for the byte-wide host
    a_r7_no_wide_on_mcs: assert property (@(posedge clk) disable iff (rst)
        (mode == BUS_MCS) |-> !io16_pull);

    // R10: a held write strobe yields a single register write
    a_r10_single_write_pulse: assert property (@(posedge clk) disable iff (rst)
        rf_wr |=> !rf_wr);

    // R11: lanes are driven only under a read strobe of the active style
    a_r11_drive_only_on_read: assert property (@(posedge clk) disable iff (rst)
        (|dout_oe) |-> ((mode == BUS_M68) ? wr_n : !rd_n));

    // R12: port strobes never collide with each other or with a register write
    a_r12_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        $countones({rf_wr, dp_wr, dp_rd}) <= 1);

endmodule

// File: tb/tb_hbus_slave.sv
module tb_hbus_slave;

    logic        clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic [1:0]  strap_mode;
    logic [3:0]  strap_pol;
    logic        cs_n;
    logic [9:0]  addr;
    logic [3:0]  sel_x;
    logic        bhe_n, rd_n, wr_n, psen;
    logic [15:0] din, dout;
    logic [1:0]  dout_oe;
    logic        rdy_pull, io16_pull, irq_req, irq_pin;
    logic [3:0]  rf_idx;
    logic [1:0]  rf_be;
    logic        rf_wr, dp_rd, dp_wr, dp_ready;
    logic [15:0] rf_wdata, rf_rdata, dp_wdata, dp_rdata;

    assign rf_rdata = {4'h5, rf_idx, 4'hC, rf_idx};

    hbus_slave dut (
        .clk(clk), .rst(rst), .strap_mode(strap_mode), .strap_pol(strap_pol),
        .cs_n(cs_n), .addr(addr), .sel_x(sel_x), .bhe_n(bhe_n), .rd_n(rd_n),
        .wr_n(wr_n), .psen(psen), .din(din), .dout(dout), .dout_oe(dout_oe),
        .rdy_pull(rdy_pull), .io16_pull(io16_pull), .irq_req(irq_req),
        .irq_pin(irq_pin), .rf_idx(rf_idx), .rf_be(rf_be), .rf_wr(rf_wr),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .dp_rd(dp_rd), .dp_wr(dp_wr),
        .dp_wdata(dp_wdata), .dp_rdata(dp_rdata), .dp_ready(dp_ready)
    );

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [1:0] m_mode;
    logic [3:0] m_pol;
    logic       m_prev;

    // {chip, hit, rd, wr, odd, even, port} from the pins, per requirements
    function automatic logic [6:0] mdl(input logic [1:0] md, input logic [3:0] pl);
        logic chip, rd, wr, ev, od, hit, port;
        chip = !cs_n && (addr[9:5] == 5'h18) && (sel_x == pl) && (md != 2'd3 || psen);
        ev = !addr[0];
        if (md == 2'd2) begin
            rd = (!addr[0] || !bhe_n) && wr_n;
            wr = (!addr[0] || !bhe_n) && !wr_n;
            od = !bhe_n;
        end else begin
            rd = !rd_n;
            wr = !wr_n && rd_n;
            od = (md == 2'd3) ? addr[0] : !bhe_n;
        end
        hit  = chip && (rd || wr) && (ev || od);
        port = addr[4:1] == 4'd8;
        return {chip, hit, rd, wr, od, ev, port};
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_mode <= strap_mode;
            m_pol  <= strap_pol;
            m_prev <= 1'b0;
        end else begin
            logic [6:0] v;
            v = mdl(m_mode, m_pol);
            m_prev <= v[5];
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            chk("R2 quiet in reset", {dout_oe, rf_wr, dp_wr, dp_rd}, 0);
        end else if (m_mode !== 2'bx) begin
            logic [6:0]  v;
            logic        chip, hit, rd, wr, od, ev, port, start, ackok;
            logic [15:0] word, edout, mask;
            logic [7:0]  we, wo;
            logic [1:0]  eoe;
            string       ltag;
            v = mdl(m_mode, m_pol);
            {chip, hit, rd, wr, od, ev, port} = v;
            word  = port ? dp_rdata : {4'h5, addr[4:1], 4'hC, addr[4:1]};
            start = hit && !m_prev;
            case (m_mode)
                2'd2: begin
                    eoe = {ev, od}; edout = {word[7:0], word[15:8]};
                    we = din[15:8]; wo = din[7:0]; ltag = "R4 68000 lanes";
                end
                2'd3: begin
                    eoe = 2'b01; edout = {8'h00, od ? word[15:8] : word[7:0]};
                    we = din[7:0]; wo = din[7:0]; ltag = "R5 8051 lanes";
                end
                default: begin
                    eoe = {od, ev}; edout = word;
                    we = din[7:0]; wo = din[15:8]; ltag = "R3 ISA/80186 lanes";
                end
            endcase
            if (!(hit && rd)) eoe = 2'b00;
            if (cs_n) ltag = "R2 standby";
            else if (!chip) ltag = "R6 select match";
            mask = {{8{eoe[1]}}, {8{eoe[0]}}};
            chk(ltag, dout_oe, eoe);
            chk("R11 read data", dout & mask, edout & mask);
            chk("R10 register write pulse", rf_wr, start && wr && !port);
            if (start && wr && !port) begin
                chk("R10 register write data", {rf_idx, rf_be, rf_wdata}, {addr[4:1], od, ev, wo, we});
            end
            chk("R12 port write pulse", dp_wr, start && wr && port);
            chk("R12 port read pulse", dp_rd, start && rd && port);
            if (start && wr && port) chk("R12 port write data", dp_wdata, {wo, we});
            ackok = !port || dp_ready;
            chk("R9 handshake", rdy_pull, hit && ((m_mode == 2'd2) ? ackok : !ackok));
            chk("R7 16-bit port", io16_pull, chip && port && (m_mode != 2'd3));
            chk("R8 interrupt polarity", irq_pin, (m_mode < 2'd2) ? irq_req : !irq_req);
        end
    end

    // ---------------- stimulus ----------------
    logic [1:0] cur_mode;
    logic [3:0] cur_pol;

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic bus_idle();
        cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; bhe_n = 1'b1; psen = 1'b1;
        addr = {5'h18, 5'h01}; sel_x = cur_pol;
    endtask

    // kind: 1 read, 2 write; be = {odd, even}
    task automatic op_start(int kind, logic [3:0] widx, logic [1:0] be, logic [15:0] data);
        logic a0;
        din   = data;
        cs_n  = 1'b0;
        sel_x = cur_pol;
        psen  = 1'b1;
        case (cur_mode)
            2'd2: begin
                a0 = !be[0]; bhe_n = !be[1]; rd_n = 1'b1; wr_n = (kind == 2) ? 1'b0 : 1'b1;
            end
            2'd3: begin
                a0 = be[1]; bhe_n = 1'b1; rd_n = (kind != 1); wr_n = (kind != 2);
            end
            default: begin
                a0 = !be[0]; bhe_n = !be[1]; rd_n = (kind != 1); wr_n = (kind != 2);
            end
        endcase
        addr = {5'h18, widx, a0};
    endtask

    task automatic op(int kind, logic [3:0] widx, logic [1:0] be, logic [15:0] data, int hold);
        op_start(kind, widx, be, data);
        step(hold);
        bus_idle();
        step(1);
    endtask

    task automatic do_reset(logic [1:0] md, logic [3:0] pl);
        cur_mode = md; cur_pol = pl;
        strap_mode = md; strap_pol = pl;
        rst = 1'b1;
        bus_idle();
        step(3);
        rst = 1'b0;
        step(1);
    endtask

    initial begin
        dp_ready = 1'b1; dp_rdata = 16'hBEEF; irq_req = 1'b0; din = '0;
        cur_mode = 2'd0; cur_pol = 4'b1010;
        strap_mode = 2'd0; strap_pol = 4'b1010;
        rst = 1'b1;
        bus_idle();
        for (int m = 0; m < 4; m++) begin
            do_reset(2'(m), 4'b1010 ^ 4'(m));
            op(2, 4'd3, 2'b11, 16'hA55A, 3);            // word write to register
            op(1, 4'd3, 2'b11, 16'h0, 3);               // word read
            op(1, 4'd5, 2'b01, 16'h0, 2);               // even byte read
            op(1, 4'd5, 2'b10, 16'h0, 2);               // odd byte read
            op(2, 4'd6, 2'b10, 16'h1234, 2);            // odd byte write
            op(2, 4'd6, 2'b01, 16'h5678, 2);            // even byte write
            // data-port write, not ready then ready
            dp_ready = 1'b0;
            op_start(2, 4'd8, 2'b11, 16'hCAFE);
            step(2); dp_ready = 1'b1; step(2);
            bus_idle(); step(1);
            // data-port read, not ready then ready
            dp_ready = 1'b0; dp_rdata = 16'h3C71 + 16'(m);
            op_start(1, 4'd8, 2'b11, 16'h0);
            step(2); dp_ready = 1'b1; step(2);
            bus_idle(); step(1);
            // wrong extension select
            op_start(1, 4'd2, 2'b11, 16'h0); sel_x = ~cur_pol; step(2);
            bus_idle(); step(1);
            // wrong tag
            op_start(2, 4'd2, 2'b11, 16'h9999); addr[9:5] = 5'h19; step(2);
            bus_idle(); step(1);
            // psen low
            op_start(1, 4'd8, 2'b01, 16'h0); psen = 1'b0; step(2);
            bus_idle(); step(1);
            // strobes with chip select high
            op_start(2, 4'd4, 2'b11, 16'h7777); cs_n = 1'b1; step(2);
            bus_idle(); step(1);
            // interrupt both levels
            irq_req = 1'b1; step(2);
            chk("R8 irq asserted level", irq_pin, (m < 2) ? 1'b1 : 1'b0);
            irq_req = 1'b0; step(1);
            // straps move after reset: must be ignored
            strap_mode = 2'(m) ^ 2'b10; strap_pol = ~strap_pol; step(2);
            irq_req = 1'b1; step(1);
            chk("R1 straps ignored after reset", irq_pin, (m < 2) ? 1'b1 : 1'b0);
            irq_req = 1'b0;
            op(1, 4'd3, 2'b01, 16'h0, 2);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule